// File: doc/BRIEF.md
# Interrupt Aggregator with Store-Based Delivery

This block gathers up to 32 interrupt lines into one register-mapped controller. A rising edge on a line is recorded in a pending register, which is cleared when software touches it. If the line is enabled in the mask register, the edge is also recorded in a sticky request register and queued for delivery. A delivery is a single 32-bit store on a master port. The store goes to the 32-byte-aligned base of a programmable target address, and its data is the low five bits of that address. The receiving processor decodes that value as its interrupt number. A bus-error bit in the control register suppresses the store but still records the request.

A slave register port gives access to the interrupt registers and to some miscellaneous registers. The miscellaneous registers are a seconds counter with a writable offset, a power-control register that can raise a power-off pulse, a version register, an error-log register and an arbitration register. Each slave access is answered one cycle later by `s_ack`, with read data and an error flag.

The master port uses valid/ready handshaking, and back-pressure works as follows. Once `m_valid` is high, the address, data and source index stay stable until a cycle in which `m_ready` is high. Deliveries that arrive while a store is stalled are queued. Each line keeps at most one queued delivery. Queued lines are sent one at a time, lowest line index first.

Top module: `irq_msg_ctrl`

## Requirements
- R1: A rising edge on `irq_in[n]` sets bit n of the pending register whatever the mask is. A line that stays low, or that stays high after its edge, changes nothing.
- R2: A rising edge on `irq_in[n]` while mask bit n is 1 sets bit n of the request register and queues one delivery. While mask bit n is 0, neither happens.
- R3: A delivery presents `m_addr` as the target register with bits [4:0] cleared, and `m_data` as target bits [4:0] zero-extended. The word is big-endian: `m_data[31:24]` is the byte at the lowest address.
- R4: While control bit 0 (bus error) is 1, no store is issued. The request bit is still recorded.
- R5: A read of the pending register returns its current value and clears it. A write clears it whatever the data. An edge in the same cycle as the clear stays recorded.
- R6: Writes to the request register and to the version register are ignored. The version register always reads 0.
- R7: A read of the control register returns bit 0 only. All other bits read 0.
- R8: After reset, the target register is 0xFFFB0003. The mask, pending, request, error-log and arbitration registers are 0, `m_valid` is 0 and `pwr_off` is 0.
- R9: The seconds register reads as a free-running seconds count plus an offset. A write sets the offset so that the value read continues counting from the value written.
- R10: Writing exactly 0x00000002 to the power register raises `pwr_off` for exactly one cycle, the cycle after the write. Any other value has no effect. The power register and the I/O-reset register read 0.
- R11: While `m_valid` is 1 and `m_ready` is 0, `m_addr`, `m_data` and `m_src` stay stable. Each queued line is delivered exactly once, in ascending line order, and `m_src` carries the line index.
- R12: An access to an undecoded word offset (11 to 15) returns `s_err` = 1 with read data 0. A write there changes no register.
- R13: Word offsets are: 0 request, 1 mask, 2 pending, 3 control, 4 target, 5 seconds, 6 power, 7 version, 8 I/O-reset, 9 error-log, 10 arbitration. The mask, error-log, arbitration and target registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NLINES | Interrupt lines, rising-edge detected |
| s_req | input | 1 | Slave access strobe |
| s_we | input | 1 | Slave write (1) or read (0) |
| s_addr | input | 4 | Slave word offset |
| s_wdata | input | 32 | Slave write data |
| s_ack | output | 1 | Access answered, one cycle after `s_req` |
| s_rdata | output | 32 | Read data, valid with `s_ack` |
| s_err | output | 1 | Undecoded offset, valid with `s_ack` |
| m_valid | output | 1 | Delivery store valid |
| m_ready | input | 1 | Store accepted when high with `m_valid` |
| m_addr | output | 32 | Store address, 32-byte aligned |
| m_data | output | 32 | Store data, big-endian word |
| m_src | output | SRC_W | Line index of this delivery |
| pwr_off | output | 1 | One-cycle power-off request |

## Verification
The bench raises three lines in one cycle while `m_ready` is held low. A queue that dropped, repeated or reordered lines would show up as a wrong `m_src` sequence or an extra store. It drives a pending-register write in the same cycle as a new edge, where a design that let the clear win would lose the edge. It sets the bus-error bit and checks that a request is recorded with no store; a design that gated the whole path on that bit would miss the request. It also writes a non-matching value to the power register, where a loose compare would fire `pwr_off`, and it reads the seconds counter right after a write, where a design that stored the raw value would jump.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int REG_AW   = 4;
  localparam int DW       = 32;
  localparam int BERR_BIT = 0;
  localparam int ALIGN_W  = 5;
  localparam logic [DW-1:0] PWR_OFF_CODE = 32'h0000_0002;

  typedef enum logic [REG_AW-1:0] {
    OFF_REQ  = 4'd0,
    OFF_MASK = 4'd1,
    OFF_PEND = 4'd2,
    OFF_CTRL = 4'd3,
    OFF_TGT  = 4'd4,
    OFF_SEC  = 4'd5,
    OFF_PWR  = 4'd6,
    OFF_VER  = 4'd7,
    OFF_IORS = 4'd8,
    OFF_ELOG = 4'd9,
    OFF_ARB  = 4'd10
  } reg_off_e;
endpackage

// File: rtl/irq_msg_seconds.sv
module irq_msg_seconds #(
  parameter int TICKS_PER_SEC = 100_000_000,
  parameter int DW            = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] value
);
  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);

  logic [PRE_W-1:0] pre_q;
  logic [DW-1:0]    sec_q;
  logic [DW-1:0]    off_q;
  logic             tick;

  assign tick  = (pre_q == PRE_LAST);
  assign value = sec_q + off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      sec_q <= '0;
      off_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) sec_q <= sec_q + 1'b1;
      if (wr_en) off_q <= wdata - sec_q;
    end
  end
endmodule

// File: rtl/irq_msg_sched.sv
module irq_msg_sched #(
  parameter int NLINES = 32,
  parameter int DW     = 32,
  parameter int SRC_W  = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] fire,
  input  logic [DW-1:0]     target,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DW-1:0]     m_addr,
  output logic [DW-1:0]     m_data,
  output logic [SRC_W-1:0]  m_src
);
  import irq_msg_pkg::*;

  logic [NLINES-1:0] owe_q;
  logic [NLINES-1:0] grant;
  logic [SRC_W-1:0]  pick_idx;
  logic              found;
  logic              launch;

  always_comb begin
    pick_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < NLINES; i++) begin
      if (owe_q[i] && !found) begin
        pick_idx = SRC_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign launch = !m_valid && found;
  assign grant  = launch ? (NLINES'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owe_q   <= '0;
      m_valid <= 1'b0;
      m_addr  <= '0;
      m_data  <= '0;
      m_src   <= '0;
    end else begin
      owe_q <= (owe_q & ~grant) | fire;
      if (launch) begin
        m_valid <= 1'b1;
        m_addr  <= {target[DW-1:ALIGN_W], {ALIGN_W{1'b0}}};
        m_data  <= {{(DW-ALIGN_W){1'b0}}, target[ALIGN_W-1:0]};
        m_src   <= pick_idx;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_msg_regs.sv
module irq_msg_regs #(
  parameter int NLINES = 32,
  parameter int DW     = 32,
  parameter logic [DW-1:0] TARGET_RST = 32'hFFFB_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              s_req,
  input  logic              s_we,
  input  logic [3:0]        s_addr,
  input  logic [DW-1:0]     s_wdata,
  output logic              s_ack,
  output logic [DW-1:0]     s_rdata,
  output logic              s_err,
  input  logic [DW-1:0]     sec_value,
  output logic              sec_wr,
  output logic [NLINES-1:0] fire,
  output logic [DW-1:0]     target,
  output logic              pwr_off
);
  import irq_msg_pkg::*;

  logic [NLINES-1:0] line_q;
  logic [NLINES-1:0] edge_ev;
  logic [NLINES-1:0] pend_q;
  logic [NLINES-1:0] req_q;
  logic [DW-1:0]     mask_q;
  logic              berr_q;
  logic [DW-1:0]     tgt_q;
  logic [DW-1:0]     elog_q;
  logic [DW-1:0]     arb_q;
  logic [DW-1:0]     rd_mux;
  logic              decoded;
  logic              wr;
  logic              pend_clr;

  assign edge_ev  = irq_in & ~line_q;
  assign fire     = edge_ev & mask_q[NLINES-1:0] & {NLINES{~berr_q}};
  assign target   = tgt_q;
  assign wr       = s_req && s_we;
  assign pend_clr = s_req && (s_addr == OFF_PEND);
  assign sec_wr   = wr && (s_addr == OFF_SEC);

  always_comb begin
    decoded = 1'b1;
    rd_mux  = '0;
    case (s_addr)
      OFF_REQ:  rd_mux = DW'(req_q);
      OFF_MASK: rd_mux = mask_q;
      OFF_PEND: rd_mux = DW'(pend_q);
      OFF_CTRL: rd_mux[BERR_BIT] = berr_q;
      OFF_TGT:  rd_mux = tgt_q;
      OFF_SEC:  rd_mux = sec_value;
      OFF_PWR, OFF_VER, OFF_IORS: rd_mux = '0;
      OFF_ELOG: rd_mux = elog_q;
      OFF_ARB:  rd_mux = arb_q;
      default:  decoded = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      pend_q  <= '0;
      req_q   <= '0;
      mask_q  <= '0;
      berr_q  <= 1'b0;
      tgt_q   <= TARGET_RST;
      elog_q  <= '0;
      arb_q   <= '0;
      s_ack   <= 1'b0;
      s_err   <= 1'b0;
      s_rdata <= '0;
      pwr_off <= 1'b0;
    end else begin
      line_q  <= irq_in;
      pend_q  <= (pend_clr ? '0 : pend_q) | edge_ev;
      req_q   <= req_q | (edge_ev & mask_q[NLINES-1:0]);
      s_ack   <= s_req;
      s_err   <= s_req && !decoded;
      s_rdata <= (s_req && !s_we) ? rd_mux : '0;
      pwr_off <= wr && (s_addr == OFF_PWR) && (s_wdata == PWR_OFF_CODE);
      if (wr) begin
        case (s_addr)
          OFF_MASK: mask_q <= s_wdata;
          OFF_CTRL: berr_q <= s_wdata[BERR_BIT];
          OFF_TGT:  tgt_q  <= s_wdata;
          OFF_ELOG: elog_q <= s_wdata;
          OFF_ARB:  arb_q  <= s_wdata;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl #(
  parameter int NLINES        = 32,
  parameter int TICKS_PER_SEC = 100_000_000,
  parameter logic [31:0] TARGET_RST = 32'hFFFB_0003,
  parameter int SRC_W         = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              s_req,
  input  logic              s_we,
  input  logic [3:0]        s_addr,
  input  logic [31:0]       s_wdata,
  output logic              s_ack,
  output logic [31:0]       s_rdata,
  output logic              s_err,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [31:0]       m_addr,
  output logic [31:0]       m_data,
  output logic [SRC_W-1:0]  m_src,
  output logic              pwr_off
);
  import irq_msg_pkg::*;

  logic [DW-1:0]     sec_value;
  logic              sec_wr;
  logic [NLINES-1:0] fire;
  logic [DW-1:0]     target;

  irq_msg_seconds #(.TICKS_PER_SEC(TICKS_PER_SEC), .DW(DW)) u_sec (
    .clk(clk), .rst_n(rst_n), .wr_en(sec_wr), .wdata(s_wdata), .value(sec_value)
  );

  irq_msg_regs #(.NLINES(NLINES), .DW(DW), .TARGET_RST(TARGET_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_ack(s_ack), .s_rdata(s_rdata), .s_err(s_err),
    .sec_value(sec_value), .sec_wr(sec_wr),
    .fire(fire), .target(target), .pwr_off(pwr_off)
  );

  irq_msg_sched #(.NLINES(NLINES), .DW(DW), .SRC_W(SRC_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .fire(fire), .target(target),
    .m_valid(m_valid), .m_ready(m_ready),
    .m_addr(m_addr), .m_data(m_data), .m_src(m_src)
  );
endmodule

// File: rtl/irq_msg_ctrl_chk.sv
module irq_msg_ctrl_chk #(
  parameter int SRC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_req,
  input logic             s_we,
  input logic [3:0]       s_addr,
  input logic             s_ack,
  input logic [31:0]      s_rdata,
  input logic             s_err,
  input logic             m_valid,
  input logic             m_ready,
  input logic [31:0]      m_addr,
  input logic [31:0]      m_data,
  input logic [SRC_W-1:0] m_src,
  input logic             pwr_off
);
  import irq_msg_pkg::*;

  AST_STORE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> m_addr[4:0] == 5'd0); // R3
  AST_STORE_DATA_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> m_data[31:5] == 27'd0); // R3
  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data) && $stable(m_src))); // R11
  AST_PWR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |=> !pwr_off); // R10
  AST_PWR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |-> $past(s_req && s_we && s_addr == OFF_PWR)); // R10
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    s_err |-> (s_ack && s_rdata == 32'd0)); // R12
  AST_VERSION_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ack && $past(s_req && !s_we && s_addr == OFF_VER)) |-> s_rdata == 32'd0); // R6
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack |-> $past(s_req)); // R13
endmodule

bind irq_msg_ctrl irq_msg_ctrl_chk #(.SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
  .s_ack(s_ack), .s_rdata(s_rdata), .s_err(s_err),
  .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data),
  .m_src(m_src), .pwr_off(pwr_off)
);

// File: tb/irq_msg_ctrl_bench.sv
`timescale 1ns/1ps
module irq_msg_ctrl_bench;
  import irq_msg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        s_req = 1'b0, s_we = 1'b0;
  logic [3:0]  s_addr = '0;
  logic [31:0] s_wdata = '0;
  logic        s_ack, s_err, m_valid, pwr_off;
  logic        m_ready = 1'b0;
  logic [31:0] s_rdata, m_addr, m_data;
  logic [4:0]  m_src;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_msg_ctrl #(.NLINES(32), .TICKS_PER_SEC(8)) u_irq_msg_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_ack(s_ack), .s_rdata(s_rdata), .s_err(s_err),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data),
    .m_src(m_src), .pwr_off(pwr_off)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, output logic e);
    @(negedge clk); s_req = 1; s_we = 1; s_addr = a; s_wdata = d;
    @(negedge clk); s_req = 0; s_we = 0; e = s_err;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); s_req = 1; s_we = 0; s_addr = a;
    @(negedge clk); s_req = 0; d = s_rdata; e = s_err;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic no_store(input string req, input int cyc);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (m_valid) seen = 1; end
    chk(!seen, req, "unexpected store", 32'(seen), 0);
  endtask

  task automatic wait_store(input logic [31:0] ea, input logic [31:0] ed,
                            input logic [4:0] es, input int hold);
    bit found = 0;
    for (int i = 0; i < 20 && !found; i++) begin @(negedge clk); if (m_valid) found = 1; end
    chk(found, "R2", "store seen", 32'(found), 1);
    if (found) begin
      chk(m_addr == ea, "R3", "store addr", m_addr, ea);
      chk(m_data == ed, "R3", "store data", m_data, ed);
      chk(m_src == es, "R11", "store source order", 32'(m_src), 32'(es));
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(m_valid && m_addr == ea && m_src == es, "R11", "held under back-pressure",
            m_addr, ea);
      end
      m_ready = 1; @(negedge clk); m_ready = 0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    chk(!m_valid && !pwr_off, "R8", "outputs idle", {30'd0, m_valid, pwr_off}, 0);
    bus_rd(OFF_TGT, d, e);  chk(d == 32'hFFFB_0003, "R8", "target reset", d, 32'hFFFB_0003);
    bus_rd(OFF_MASK, d, e); chk(d == 0, "R8", "mask reset", d, 0);
    bus_rd(OFF_REQ, d, e);  chk(d == 0, "R8", "request reset", d, 0);
    bus_rd(OFF_ELOG, d, e); chk(d == 0, "R8", "errlog reset", d, 0);
  endtask

  task automatic t_masked();
    logic [31:0] d; logic e;
    pulse(32'h8);
    no_store("R2", 8);
    bus_rd(OFF_REQ, d, e);  chk(d == 0, "R2", "masked request", d, 0);
    bus_rd(OFF_PEND, d, e); chk(d == 32'h8, "R1", "pending set", d, 32'h8);
    bus_rd(OFF_PEND, d, e); chk(d == 0, "R5", "pending cleared by read", d, 0);
    @(negedge clk); irq_in = 32'h10;
    repeat (4) @(negedge clk);
    irq_in = 32'h0;
    bus_rd(OFF_PEND, d, e); chk(d == 32'h10, "R1", "held line once", d, 32'h10);
    pulse(32'h2);
    bus_wr(OFF_PEND, 32'h0, e);
    bus_rd(OFF_PEND, d, e); chk(d == 0, "R5", "pending cleared by write", d, 0);
    @(negedge clk); s_req = 1; s_we = 1; s_addr = OFF_PEND; s_wdata = '1; irq_in = 32'h1000;
    @(negedge clk); s_req = 0; s_we = 0; irq_in = 0;
    bus_rd(OFF_PEND, d, e); chk(d == 32'h1000, "R5", "edge survives clear", d, 32'h1000);
  endtask

  task automatic t_readonly();
    logic [31:0] d; logic e;
    bus_wr(OFF_REQ, 32'hFFFF_FFFF, e);
    bus_rd(OFF_REQ, d, e); chk(d == 0, "R6", "request write ignored", d, 0);
    bus_wr(OFF_VER, 32'h5, e);
    bus_rd(OFF_VER, d, e); chk(d == 0, "R6", "version reads 0", d, 0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] d; logic e;
    bus_wr(OFF_CTRL, 32'hFFFF_FFFE, e);
    bus_rd(OFF_CTRL, d, e); chk(d == 0, "R7", "ctrl other bits", d, 0);
    bus_wr(OFF_CTRL, 32'h0000_0001, e);
    bus_rd(OFF_CTRL, d, e); chk(d == 1, "R7", "ctrl bus-error bit", d, 1);
    bus_wr(OFF_CTRL, 32'h0, e);
    bus_wr(OFF_ELOG, 32'hA5A5_0F0F, e);
    bus_wr(OFF_ARB, 32'h0000_00C3, e);
    bus_wr(OFF_MASK, 32'h0F0F_0000, e);
    bus_rd(OFF_ELOG, d, e); chk(d == 32'hA5A5_0F0F, "R13", "errlog readback", d, 32'hA5A5_0F0F);
    bus_rd(OFF_ARB, d, e);  chk(d == 32'hC3, "R13", "arb readback", d, 32'hC3);
    bus_rd(OFF_MASK, d, e); chk(d == 32'h0F0F_0000, "R13", "mask readback", d, 32'h0F0F_0000);
  endtask

  task automatic t_undecoded();
    logic [31:0] d; logic e;
    bus_rd(4'd15, d, e);
    chk(e && d == 0, "R12", "undecoded read", d, 0);
    bus_wr(4'd11, 32'hFFFF_FFFF, e);
    chk(e, "R12", "undecoded write err", 32'(e), 1);
    bus_rd(OFF_MASK, d, e); chk(d == 32'h0F0F_0000, "R12", "mask untouched", d, 32'h0F0F_0000);
    bus_rd(OFF_ELOG, d, e); chk(d == 32'hA5A5_0F0F, "R12", "errlog untouched", d, 32'hA5A5_0F0F);
  endtask

  task automatic t_power();
    logic [31:0] d; logic e;
    bus_wr(OFF_PWR, 32'h3, e);
    chk(!pwr_off, "R10", "non-matching value", 32'(pwr_off), 0);
    bus_wr(OFF_PWR, 32'h102, e);
    chk(!pwr_off, "R10", "upper bits differ", 32'(pwr_off), 0);
    bus_wr(OFF_PWR, 32'h2, e);
    chk(pwr_off, "R10", "pulse raised", 32'(pwr_off), 1);
    @(negedge clk);
    chk(!pwr_off, "R10", "pulse one cycle", 32'(pwr_off), 0);
    bus_rd(OFF_PWR, d, e);  chk(d == 0, "R10", "power reads 0", d, 0);
    bus_rd(OFF_IORS, d, e); chk(d == 0, "R10", "io-reset reads 0", d, 0);
  endtask

  task automatic t_seconds();
    logic [31:0] d; logic e;
    bus_wr(OFF_SEC, 32'd100, e);
    bus_rd(OFF_SEC, d, e);
    chk(d >= 100 && d <= 101, "R9", "continues from written", d, 100);
    repeat (40) @(negedge clk);
    bus_rd(OFF_SEC, d, e);
    chk(d >= 104 && d <= 107, "R9", "counts on", d, 105);
  endtask

  task automatic t_deliver();
    logic [31:0] d; logic e;
    bus_wr(OFF_MASK, 32'hFFFF_FFFF, e);
    bus_wr(OFF_TGT, 32'h1234_5667, e);
    bus_rd(OFF_TGT, d, e); chk(d == 32'h1234_5667, "R13", "target readback", d, 32'h1234_5667);
    pulse(32'h20);
    wait_store(32'h1234_5660, 32'h7, 5'd5, 3);
    bus_rd(OFF_REQ, d, e); chk(d[5], "R2", "request recorded", d, 32'h20);
    no_store("R11", 6);
  endtask

  task automatic t_queue();
    logic [31:0] d; logic e;
    bus_wr(OFF_TGT, 32'h8000_003E, e);
    pulse(32'h0002_0204);
    wait_store(32'h8000_0020, 32'h1E, 5'd2, 2);
    wait_store(32'h8000_0020, 32'h1E, 5'd9, 1);
    wait_store(32'h8000_0020, 32'h1E, 5'd17, 0);
    no_store("R11", 10);
    bus_rd(OFF_PEND, d, e);
  endtask

  task automatic t_berr();
    logic [31:0] d; logic e;
    bus_wr(OFF_CTRL, 32'hFFFF_FFFF, e);
    pulse(32'h40);
    no_store("R4", 10);
    bus_rd(OFF_REQ, d, e); chk(d[6], "R4", "request still recorded", d, 32'h40);
    bus_wr(OFF_CTRL, 32'h0, e);
    no_store("R4", 5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masked();
    t_readonly();
    t_ctrl_rw();
    t_undecoded();
    t_power();
    t_seconds();
    t_deliver();
    t_queue();
    t_berr();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule